// File: doc/BRIEF.md
# Octal Double-Buffered Converter Code Port

This block is the synchronous digital front end of an eight-channel, 14-bit converter array. A host writes a code into one channel's holding register by address. A separate global commit strobe then moves all eight holding registers into the output registers at the same clock edge, so every channel changes together. Each output code appears on a parallel port in offset binary. The same code also appears as a signed value, formed by inverting the top bit, for checking.

The host side uses active-low strobes: select, hold-load, commit, read, hold-clear and output-clear. They are sampled on the rising edge of one clock. The shared data bus is split into an input, an output and a drive enable. The pad logic outside the block joins them into one bidirectional bus. A read puts the addressed holding register on the bus output one cycle later. When no read is active, the enable stays low.

Holding and committing in the same cycle makes the addressed channel pass-through: the bus data lands in that channel's output at once. Either bank can be cleared to mid-scale, 0x2000, which is the zero-volt code.

Top module: `octal_dac_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output code becomes 0x2000 and `bus_oe` becomes 0. The holding registers also become 0x2000.
- R2: With `sel_n` and `hold_ld_n` low at an edge, `bus_in` is written into the holding register of the channel given by `chan` (0 = first, 7 = eighth). The other seven holding registers keep their values.
- R3: Loading a holding register alone leaves every output code unchanged.
- R4: With `commit_n` low at an edge, all eight output codes take their holding-register values at that same edge, whatever the state of `sel_n`.
- R5: With `sel_n`, `hold_ld_n` and `commit_n` all low at an edge, the addressed channel's output takes `bus_in` directly at that edge. The other channels take their holding values.
- R6: With `sel_n` and `read_n` low at an edge, after that edge `bus_oe` is 1 and `bus_out` holds the addressed holding register. After any edge without such a read, `bus_oe` is 0, including when `read_n` is low but `sel_n` is high.
- R7: With `hold_clr_n` low at an edge, all eight holding registers become 0x2000, regardless of select, address or data. This clear wins over a hold-load in the same cycle.
- R8: With `out_clr_n` low at an edge, all eight output codes become 0x2000. This clear wins over a commit in the same cycle.
- R9: Each signed view is the output code with bit 13 inverted. Code 0x2000 reads 0, 0x0000 reads -8192 and 0x3FFF reads +8191.
- R10: A read at the same edge as a hold-load to the same channel returns the value held before that load.
- R11: A hold-load with `sel_n` high changes no holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low block reset |
| sel_n | input | 1 | Active-low select; gates hold-load and read |
| chan | input | 3 | Channel address |
| hold_ld_n | input | 1 | Active-low hold-register load |
| commit_n | input | 1 | Active-low global commit into the outputs |
| read_n | input | 1 | Active-low readback of the addressed holding register |
| hold_clr_n | input | 1 | Active-low clear of all holding registers to mid-scale |
| out_clr_n | input | 1 | Active-low clear of all output registers to mid-scale |
| bus_in | input | 14 | Data bus, inbound |
| bus_out | output | 14 | Data bus, outbound readback value |
| bus_oe | output | 1 | Drive enable for the outbound bus |
| code_o | output | 112 | Eight output codes, channel n at bits 14n+13 down to 14n |
| code_s_o | output | 112 | Eight signed views, same packing |

## Verification
Several functions can act in the same cycle. A read and a hold-load to the same channel share one edge. In that case the bench expects the old value on the bus and then confirms the new value with a second read. Each clear is also applied in the same cycle as the load or commit to its own bank, with data that differs from mid-scale. The bench judges the outcome at the outputs or by readback: mid-scale everywhere shows that the clear took priority. Pass-through is the overlap of a hold-load and a commit. It is judged by checking the addressed output and an unaddressed one after the same edge.

// File: rtl/dacp_pkg.sv
// Package: shared sizes and helpers for the octal converter code port.
// Assumes offset-binary codes whose mid-scale is the top bit alone.
package dacp_pkg;
    parameter int CH_N   = 8;
    parameter int CODE_W = 14;

    // Mid-scale code for a given width (zero volts in offset binary).
    function automatic logic [31:0] mid_code(input int w);
        return 32'(1) << (w - 1);
    endfunction
endpackage

// File: rtl/dacp_decode.sv
// Module: dacp_decode
// Turns the active-low host strobes into active-high per-channel write
// selects and global controls. Assumes the strobes are already stable
// around the clock edge (synchronous host).
module dacp_decode #(
    parameter int CH_N   = dacp_pkg::CH_N,
    parameter int ADDR_W = $clog2(CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] chan,
    input  logic              hold_ld_n,
    input  logic              commit_n,
    input  logic              read_n,
    input  logic              hold_clr_n,
    input  logic              out_clr_n,
    output logic [CH_N-1:0]   wr_sel,
    output logic              copy_all,
    output logic              clr_hold,
    output logic              clr_out,
    output logic              rd_en
);
    logic wr_en;

    // Qualify the select-gated strobes and the global ones.
    always_comb begin
        wr_en    = !sel_n && !hold_ld_n;
        rd_en    = !sel_n && !read_n;
        copy_all = !commit_n;
        clr_hold = !hold_clr_n;
        clr_out  = !out_clr_n;
    end

    // One address comparator per channel.
    for (genvar i = 0; i < CH_N; i++) begin : g_sel
        assign wr_sel[i] = wr_en && (chan == ADDR_W'(i));
    end

    // R2
    wr_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel))
        else $error("more than one channel selected for write");

    // R11
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (wr_sel == '0))
        else $error("write select active while deselected");
endmodule

// File: rtl/dacp_channel.sv
// Module: dacp_channel
// One converter channel: a holding register loaded by address and an
// output register loaded by the global commit. Clears take priority
// over loads in their own bank. Holding and committing together passes
// bus data straight into the output.
module dacp_channel #(
    parameter int CODE_W = dacp_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              copy_all,
    input  logic              clr_hold,
    input  logic              clr_out,
    input  logic [CODE_W-1:0] bus_in,
    output logic [CODE_W-1:0] hold_q,
    output logic [CODE_W-1:0] out_q,
    output logic [CODE_W-1:0] out_signed
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(dacp_pkg::mid_code(CODE_W));
    localparam logic [CODE_W:0]   MIDX = (CODE_W+1)'(dacp_pkg::mid_code(CODE_W));

    // Holding register: clear, then addressed load.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= MID;
        else if (clr_hold) hold_q <= MID;
        else if (wr_sel)   hold_q <= bus_in;
    end

    // Output register: clear, then commit (pass-through when addressed).
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= MID;
        else if (clr_out)  out_q <= MID;
        else if (copy_all) out_q <= wr_sel ? bus_in : hold_q;
    end

    // Signed view: offset binary with the top bit flipped.
    assign out_signed = {~out_q[CODE_W-1], out_q[CODE_W-2:0]};

    // R9
    always_comb begin
        if (rst_n) begin
            sview_chk: assert ({out_signed[CODE_W-1], out_signed} == ({1'b0, out_q} - MIDX))
                else $error("signed view does not equal code minus mid-scale");
        end
    end

    // R7
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hold |=> (hold_q == MID))
        else $error("holding register not cleared");

    // R8
    out_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out |=> (out_q == MID))
        else $error("output register not cleared");

    // R4
    out_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_all && !clr_out && !wr_sel) |=> (out_q == $past(hold_q)))
        else $error("commit did not copy holding value");

    // R3
    out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_all && !clr_out) |=> $stable(out_q))
        else $error("output changed without commit or clear");

    // R5
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_all && wr_sel && !clr_out) |=> (out_q == $past(bus_in)))
        else $error("pass-through did not reach the output");
endmodule

// File: rtl/dacp_readback.sv
// Module: dacp_readback
// Registers the addressed holding value onto the outbound bus when a read
// is sampled, and drops the drive enable on every other cycle. Since it
// samples the holding registers before they update, a read alongside a
// load returns the earlier value.
module dacp_readback #(
    parameter int CH_N   = dacp_pkg::CH_N,
    parameter int CODE_W = dacp_pkg::CODE_W,
    parameter int ADDR_W = $clog2(CH_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] chan,
    input  logic [CODE_W-1:0] hold [CH_N],
    output logic [CODE_W-1:0] bus_out,
    output logic              bus_oe
);
    logic [CODE_W-1:0] pick;

    // Address mux over the holding registers.
    always_comb begin
        pick = '0;
        for (int i = 0; i < CH_N; i++)
            if (chan == ADDR_W'(i)) pick = hold[i];
    end

    // Bus output register and its drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            bus_out <= rd_en ? pick : '0;
            bus_oe  <= rd_en;
        end
    end

    // R6
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_oe)
        else $error("bus not driven after read");

    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !bus_oe)
        else $error("bus driven without read");
endmodule

// File: rtl/octal_dac_port.sv
// Module: octal_dac_port
// Top of the eight-channel double-buffered code port. It combines the strobe
// decoder, one register pair per channel and the readback path, then
// flattens the output codes and their signed views onto wide ports.
// Assumes a synchronous host that meets setup and hold to clk.
module octal_dac_port #(
    parameter int CH_N   = dacp_pkg::CH_N,
    parameter int CODE_W = dacp_pkg::CODE_W,
    parameter int ADDR_W = $clog2(CH_N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic [ADDR_W-1:0]      chan,
    input  logic                   hold_ld_n,
    input  logic                   commit_n,
    input  logic                   read_n,
    input  logic                   hold_clr_n,
    input  logic                   out_clr_n,
    input  logic [CODE_W-1:0]      bus_in,
    output logic [CODE_W-1:0]      bus_out,
    output logic                   bus_oe,
    output logic [CH_N*CODE_W-1:0] code_o,
    output logic [CH_N*CODE_W-1:0] code_s_o
);
    logic [CH_N-1:0]   wr_sel;
    logic              copy_all;
    logic              clr_hold;
    logic              clr_out;
    logic              rd_en;
    logic [CODE_W-1:0] hold   [CH_N];
    logic [CODE_W-1:0] outc   [CH_N];
    logic [CODE_W-1:0] outs   [CH_N];

    dacp_decode #(.CH_N(CH_N), .ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .chan      (chan),
        .hold_ld_n (hold_ld_n),
        .commit_n  (commit_n),
        .read_n    (read_n),
        .hold_clr_n(hold_clr_n),
        .out_clr_n (out_clr_n),
        .wr_sel    (wr_sel),
        .copy_all  (copy_all),
        .clr_hold  (clr_hold),
        .clr_out   (clr_out),
        .rd_en     (rd_en)
    );

    // One register pair per channel, flattened onto the wide outputs.
    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        dacp_channel #(.CODE_W(CODE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (wr_sel[i]),
            .copy_all  (copy_all),
            .clr_hold  (clr_hold),
            .clr_out   (clr_out),
            .bus_in    (bus_in),
            .hold_q    (hold[i]),
            .out_q     (outc[i]),
            .out_signed(outs[i])
        );
        assign code_o[i*CODE_W +: CODE_W]   = outc[i];
        assign code_s_o[i*CODE_W +: CODE_W] = outs[i];
    end

    dacp_readback #(.CH_N(CH_N), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_rb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .chan   (chan),
        .hold   (hold),
        .bus_out(bus_out),
        .bus_oe (bus_oe)
    );

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_oe && code_o[CODE_W-1:0] == CODE_W'(dacp_pkg::mid_code(CODE_W))))
        else $error("reset state wrong");
endmodule

// File: tb/sim_octal_dac_port.sv
// Directed bench for octal_dac_port: one task per scenario.
module sim_octal_dac_port;
    localparam int N = 8;
    localparam int W = 14;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           sel_n, hold_ld_n, commit_n, read_n, hold_clr_n, out_clr_n;
    logic [2:0]     chan;
    logic [W-1:0]   bus_in;
    logic [W-1:0]   bus_out;
    logic           bus_oe;
    logic [N*W-1:0] code_o, code_s_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] val [N];

    always #10 clk = ~clk;

    octal_dac_port u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .chan(chan),
        .hold_ld_n(hold_ld_n), .commit_n(commit_n), .read_n(read_n),
        .hold_clr_n(hold_clr_n), .out_clr_n(out_clr_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .code_o(code_o), .code_s_o(code_s_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] code(input int c);
        return code_o[c*W +: W];
    endfunction

    function automatic logic [31:0] sview(input int c);
        return 32'(int'($signed(code_s_o[c*W +: W])));
    endfunction

    task automatic idle();
        sel_n = 1; hold_ld_n = 1; commit_n = 1; read_n = 1;
        hold_clr_n = 1; out_clr_n = 1; chan = 0; bus_in = 0;
    endtask

    // One edge with the given strobes (active low), then return to idle.
    task automatic op(input bit s, input int c, input bit l1, input bit l2,
                      input bit rd, input bit c1, input bit c2, input logic [W-1:0] d);
        @(negedge clk);
        sel_n = s; chan = 3'(c); hold_ld_n = l1; commit_n = l2; read_n = rd;
        hold_clr_n = c1; out_clr_n = c2; bus_in = d;
        @(posedge clk); #2;
        idle();
    endtask

    task automatic rd_chk(input string req, input int c, input logic [W-1:0] exp);
        op(0, c, 1, 1, 0, 1, 1, 14'h1555);
        chk(req, 32'(bus_oe), 32'd1);
        chk(req, 32'(bus_out), 32'(exp));
    endtask

    task automatic t_reset();
        idle(); rst_n = 0;
        repeat (3) @(posedge clk); #2;
        rst_n = 1;
        for (int i = 0; i < N; i++) chk("R1 code", 32'(code(i)), 32'h2000);
        chk("R1 oe", 32'(bus_oe), 32'd0);
        chk("R9 mid signed", sview(3), 32'd0);
        rd_chk("R1 hold", 6, 14'h2000);
    endtask

    task automatic t_hold_load();
        for (int i = 0; i < N; i++) begin
            val[i] = 14'(i * 1013 + 7);
            op(0, i, 0, 1, 1, 1, 1, val[i]);
        end
        for (int i = 0; i < N; i++) chk("R3 no output change", 32'(code(i)), 32'h2000);
        for (int i = 0; i < N; i++) rd_chk("R2 addressed load", i, val[i]);
    endtask

    task automatic t_sel_gate();
        op(1, 3, 0, 1, 1, 1, 1, 14'h1ABC);
        rd_chk("R11 deselected load", 3, val[3]);
        op(1, 3, 1, 1, 0, 1, 1, 14'h0);
        chk("R6 read without select", 32'(bus_oe), 32'd0);
        op(0, 3, 1, 1, 1, 1, 1, 14'h0);
        chk("R6 idle release", 32'(bus_oe), 32'd0);
    endtask

    task automatic t_commit();
        op(1, 0, 1, 0, 1, 1, 1, 14'h0);
        for (int i = 0; i < N; i++) chk("R4 commit all", 32'(code(i)), 32'(val[i]));
    endtask

    task automatic t_read_during_load();
        op(0, 5, 0, 1, 0, 1, 1, 14'h0FED);
        chk("R10 old value", 32'(bus_out), 32'(val[5]));
        val[5] = 14'h0FED;
        rd_chk("R10 new value", 5, 14'h0FED);
        chk("R3 output held", 32'(code(5)), 32'(14'(5 * 1013 + 7)));
    endtask

    task automatic t_pass_through();
        op(0, 2, 0, 0, 1, 1, 1, 14'h3FFF);
        val[2] = 14'h3FFF;
        chk("R5 addressed", 32'(code(2)), 32'h3FFF);
        chk("R5 other copied", 32'(code(5)), 32'h0FED);
        chk("R9 top code", sview(2), 32'd8191);
        op(0, 0, 0, 0, 1, 1, 1, 14'h0000);
        val[0] = 0;
        chk("R5 zero code", 32'(code(0)), 32'h0);
        chk("R9 bottom code", sview(0), 32'hFFFF_E000);
    endtask

    task automatic t_clear_hold();
        op(1, 1, 0, 1, 1, 0, 1, 14'h1234);
        op(0, 1, 0, 1, 1, 0, 1, 14'h1234);
        for (int i = 0; i < N; i++) rd_chk("R7 hold clear", i, 14'h2000);
        chk("R7 outputs untouched", 32'(code(1)), 32'(val[1]));
    endtask

    task automatic t_clear_out();
        op(0, 4, 0, 1, 1, 1, 1, 14'h2ABC);
        op(1, 0, 1, 0, 1, 1, 0, 14'h0);
        for (int i = 0; i < N; i++) chk("R8 out clear", 32'(code(i)), 32'h2000);
        chk("R9 cleared signed", sview(4), 32'd0);
        rd_chk("R8 hold kept", 4, 14'h2ABC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hold_load();
        t_sel_gate();
        t_commit();
        t_read_during_load();
        t_pass_through();
        t_clear_hold();
        t_clear_out();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule